// File: doc/BRIEF.md
# EEPROM Register Burst Loader

This block reads a configuration image out of a byte-wide EEPROM and turns it into a series of 32-bit writes on an internal register bus. The image opens with a one-byte validity marker and a byte giving the number of bursts. Each burst then carries a two-byte header, holding a start DWORD address and a DWORD count, followed by the data bytes for every DWORD of that burst. A missing marker makes the loader finish without writing anything.

Every write waits until two management interfaces, the switch register interface and the PHY management interface, both report idle. Every byte fetch is checked against the EEPROM capacity that a strap selects. A fetch that would run past that capacity stops the load and raises a sticky overflow flag. The loader starts on a pulse, which stands for both reset release and a software reload. While it runs it shows busy, and at the end it parks in a finished state.

Top module: `eeprom_burst_loader`

## Requirements
- R1: The first image byte (EEPROM byte address 0) must equal A5h for any write to happen. Any other value sends the loader to the finished state with no register write.
- R2: The second byte is the burst count N, and the burst body is processed N times. When N is 0 the loader finishes directly with no write.
- R3: A burst header is two bytes. The first is an 8-bit DWORD address D and the second a DWORD count C. The k-th DWORD of the burst (k from 0) is written to register byte address {(D+k) mod 256, 2'b00} on a 10-bit bus.
- R4: Each DWORD is built from four consecutive image bytes, first byte into bits 31:24, then 23:16, 15:8, and last into 7:0.
- R5: A burst with C = 0 writes nothing, and the next byte read is the following burst header, or the loader finishes if it was the last burst.
- R6: `reg_we_o` is high for one cycle per write, and only in a cycle whose previous rising edge saw both `csr_busy_i` and `pmi_busy_i` low. Address and data stay stable while a write is pending.
- R7: A byte fetch raises `ee_req_o` with `ee_addr_o` and holds both until `ee_vld_i`. Image bytes are requested at consecutive addresses starting from 0.
- R8: With `size_sel_i` = k the EEPROM capacity is 128<<k bytes (128, 256, 512, 1024). A byte at an address at or above the capacity is never requested. Instead `ovf_o` is set and stays set until reset, and the loader goes to the finished state.
- R9: A start pulse sets `busy_o` and clears `done_o`. Entering the finished state, for any reason, clears `busy_o` and sets `done_o`, and no write occurs while `busy_o` is low.
- R10: A start pulse during a run discards any pending write and restarts from image byte 0. A later start re-runs the whole sequence.
- R11: After reset `busy_o`, `done_o`, `ovf_o`, `reg_we_o` and `ee_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start / reload pulse |
| size_sel_i | input | 2 | EEPROM size strap, capacity 128<<k bytes |
| ee_req_o | output | 1 | Byte fetch request |
| ee_addr_o | output | 10 | Byte fetch address |
| ee_vld_i | input | 1 | Fetched byte valid (one-cycle pulse) |
| ee_data_i | input | 8 | Fetched byte |
| csr_busy_i | input | 1 | Switch register interface busy |
| pmi_busy_i | input | 1 | PHY management interface busy |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 10 | Register byte address |
| reg_wdata_o | output | 32 | Register write data |
| busy_o | output | 1 | Loader running |
| done_o | output | 1 | Loader in finished state |
| ovf_o | output | 1 | Sticky EEPROM address overflow |

## Verification
The main function is driven with a three-burst image of growing lengths, which shows up any error in header decoding, byte order or address stepping. Other images cover a bad marker, a zero burst count, a zero-length burst followed by a real one, and a burst that wraps past DWORD address FFh. These separate the early-exit paths from each other and from address arithmetic errors. A long burst under the smallest size strap shows where the overflow stop falls. Random busy patterns, a held busy and a restart during the hold show that writes only leave on idle interfaces and are never lost or duplicated.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int WORD_BY  = WORD_W / BYTE_W;
  localparam int BIDX_W   = $clog2(WORD_BY);
  localparam int DWA_W    = 8;
  localparam int RA_W     = DWA_W + 2;
  localparam logic [BYTE_W-1:0] IMG_MARKER = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MARK, ST_NBURST, ST_HDR_A, ST_HDR_C, ST_DATA, ST_WRITE, ST_FIN
  } ebl_state_e;
endpackage

// File: rtl/ebl_byte_fetch.sv
module ebl_byte_fetch #(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 2,
  parameter int EE_AW     = 10,
  parameter int IMG_BASE  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             get,
  input  logic [SEL_W-1:0] size_sel,
  input  logic             ee_vld_i,
  input  logic [7:0]       ee_data_i,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic             ovf_o
);
  localparam int CW = EE_AW + 1;

  logic [CW-1:0] ptr_q;
  logic [CW-1:0] cap;

  always_comb cap = CW'(1) << (BASE_LOG2 + 32'(size_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= CW'(IMG_BASE);
      ee_req_o   <= 1'b0;
      ee_addr_o  <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      ovf_o      <= 1'b0;
    end else if (restart) begin
      ptr_q      <= CW'(IMG_BASE);
      ee_req_o   <= 1'b0;
      byte_vld_o <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      ovf_o      <= 1'b0;
      if (ee_req_o && ee_vld_i) begin
        ee_req_o   <= 1'b0;
        byte_vld_o <= 1'b1;
        byte_o     <= ee_data_i;
        ptr_q      <= ptr_q + 1'b1;
      end else if (get && !ee_req_o) begin
        if (ptr_q >= cap) begin
          ovf_o <= 1'b1;
        end else begin
          ee_req_o  <= 1'b1;
          ee_addr_o <= ptr_q[EE_AW-1:0];
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    ee_req_o && !ee_vld_i && !restart |=> ee_req_o && $stable(ee_addr_o)) // R7
    else $error("request dropped or address moved before valid");

  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ee_req_o |-> ({1'b0, ee_addr_o} < cap)) // R8
    else $error("fetch beyond strap capacity");
endmodule

// File: rtl/ebl_reg_writer.sv
module ebl_reg_writer #(
  parameter int RA_W = 10,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            issue,
  input  logic [RA_W-1:0] addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic            csr_busy_i,
  input  logic            pmi_busy_i,
  output logic            reg_we_o,
  output logic [RA_W-1:0] reg_addr_o,
  output logic [DW-1:0]   reg_wdata_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (abort) begin
        pend_q <= 1'b0;
      end else if (issue) begin
        pend_q      <= 1'b1;
        reg_addr_o  <= addr_i;
        reg_wdata_o <= data_i;
      end else if (pend_q && !csr_busy_i && !pmi_busy_i) begin
        pend_q   <= 1'b0;
        reg_we_o <= 1'b1;
      end
    end
  end

  AST_WE_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> $past(!csr_busy_i && !pmi_busy_i)) // R6
    else $error("write strobe while an interface was busy");

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |=> !reg_we_o) // R6
    else $error("write strobe longer than one cycle");

  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (rst)
    pend_q && !issue && !abort |=> $stable(reg_addr_o) && $stable(reg_wdata_o)) // R6
    else $error("pending write changed");
endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
  import ebl_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 2,
  parameter int IMG_BASE  = 0,
  localparam int EE_AW    = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEL_W-1:0] size_sel_i,
  output logic             ee_req_o,
  output logic [EE_AW-1:0] ee_addr_o,
  input  logic             ee_vld_i,
  input  logic [7:0]       ee_data_i,
  input  logic             csr_busy_i,
  input  logic             pmi_busy_i,
  output logic             reg_we_o,
  output logic [RA_W-1:0]  reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  ebl_state_e state_q;
  logic              wait_q;
  logic [7:0]        bursts_q;
  logic [7:0]        left_q;
  logic [DWA_W-1:0]  dwa_q;
  logic [WORD_W-BYTE_W-1:0] acc_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              busy_q, done_q, ovf_q;

  logic       get, byte_vld, fetch_ovf, wr_issue;
  logic [7:0] byte_d;

  always_comb begin
    get = 1'b0;
    if (!wait_q && !start_i) begin
      unique case (state_q)
        ST_MARK, ST_NBURST, ST_HDR_A, ST_HDR_C, ST_DATA: get = 1'b1;
        default: get = 1'b0;
      endcase
    end
    wr_issue = (state_q == ST_DATA) && byte_vld && (bidx_q == BIDX_W'(WORD_BY - 1)) && !start_i;
  end

  ebl_byte_fetch #(
    .BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .EE_AW(EE_AW), .IMG_BASE(IMG_BASE)
  ) u_fetch (
    .clk(clk), .rst(rst), .restart(start_i), .get(get), .size_sel(size_sel_i),
    .ee_vld_i(ee_vld_i), .ee_data_i(ee_data_i), .ee_req_o(ee_req_o),
    .ee_addr_o(ee_addr_o), .byte_vld_o(byte_vld), .byte_o(byte_d), .ovf_o(fetch_ovf)
  );

  ebl_reg_writer #(.RA_W(RA_W), .DW(WORD_W)) u_wr (
    .clk(clk), .rst(rst), .abort(start_i), .issue(wr_issue),
    .addr_i({dwa_q, 2'b00}), .data_i({acc_q, byte_d}),
    .csr_busy_i(csr_busy_i), .pmi_busy_i(pmi_busy_i),
    .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wait_q   <= 1'b0;
      bursts_q <= '0;
      left_q   <= '0;
      dwa_q    <= '0;
      acc_q    <= '0;
      bidx_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_MARK;
      wait_q  <= 1'b0;
      bidx_q  <= '0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      if (get) wait_q <= 1'b1;
      if (fetch_ovf) begin
        ovf_q   <= 1'b1;
        wait_q  <= 1'b0;
        state_q <= ST_FIN;
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
      end else if (byte_vld) begin
        wait_q <= 1'b0;
        unique case (state_q)
          ST_MARK: begin
            if (byte_d == IMG_MARKER) state_q <= ST_NBURST;
            else begin state_q <= ST_FIN; busy_q <= 1'b0; done_q <= 1'b1; end
          end
          ST_NBURST: begin
            bursts_q <= byte_d;
            if (byte_d == 8'd0) begin state_q <= ST_FIN; busy_q <= 1'b0; done_q <= 1'b1; end
            else state_q <= ST_HDR_A;
          end
          ST_HDR_A: begin
            dwa_q   <= byte_d;
            state_q <= ST_HDR_C;
          end
          ST_HDR_C: begin
            left_q <= byte_d;
            bidx_q <= '0;
            if (byte_d != 8'd0) state_q <= ST_DATA;
            else if (bursts_q == 8'd1) begin state_q <= ST_FIN; busy_q <= 1'b0; done_q <= 1'b1; end
            else begin bursts_q <= bursts_q - 1'b1; state_q <= ST_HDR_A; end
          end
          ST_DATA: begin
            acc_q  <= {acc_q[WORD_W-2*BYTE_W-1:0], byte_d};
            bidx_q <= bidx_q + 1'b1;
            if (bidx_q == BIDX_W'(WORD_BY - 1)) state_q <= ST_WRITE;
          end
          default: ;
        endcase
      end else if (state_q == ST_WRITE && reg_we_o) begin
        dwa_q  <= dwa_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q != 8'd1) state_q <= ST_DATA;
        else if (bursts_q == 8'd1) begin state_q <= ST_FIN; busy_q <= 1'b0; done_q <= 1'b1; end
        else begin bursts_q <= bursts_q - 1'b1; state_q <= ST_HDR_A; end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o) // R8
    else $error("overflow flag dropped");

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !reg_we_o) // R9
    else $error("write while not busy");

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !ee_req_o) // R7
    else $error("fetch while not busy");
endmodule

// File: tb/eeprom_burst_loader_tb.sv
module eeprom_burst_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  size_sel_i = 2'd3;
  logic        ee_req_o;
  logic [9:0]  ee_addr_o;
  logic        ee_vld_i = 1'b0;
  logic [7:0]  ee_data_i = '0;
  logic        csr_busy_i = 1'b0;
  logic        pmi_busy_i = 1'b0;
  logic        reg_we_o;
  logic [9:0]  reg_addr_o;
  logic [31:0] reg_wdata_o;
  logic        busy_o, done_o, ovf_o;

  always #10 clk = ~clk;

  eeprom_burst_loader dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .size_sel_i(size_sel_i),
    .ee_req_o(ee_req_o), .ee_addr_o(ee_addr_o), .ee_vld_i(ee_vld_i), .ee_data_i(ee_data_i),
    .csr_busy_i(csr_busy_i), .pmi_busy_i(pmi_busy_i), .reg_we_o(reg_we_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  int total = 0;
  int bad = 0;
  int writes = 0;
  bit finished = 0;
  logic [7:0]  mem [0:1023];
  logic [41:0] exp_q [$];
  int wp;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // EEPROM model with address-dependent latency
  int lat = 0;
  always @(posedge clk) begin
    if (ee_vld_i) ee_vld_i <= 1'b0;
    else if (ee_req_o) begin
      if (lat >= int'(ee_addr_o % 3)) begin
        ee_vld_i  <= 1'b1;
        ee_data_i <= mem[ee_addr_o];
        lat <= 0;
      end else lat <= lat + 1;
    end
  end

  // busy generators
  bit rnd_busy = 0;
  bit hold_csr = 0;
  logic [7:0] lf = 8'h5B;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    csr_busy_i = hold_csr | (rnd_busy & lf[0] & lf[2]);
    pmi_busy_i = rnd_busy & lf[1] & lf[4];
  end

  // monitor / scoreboard
  logic seen_busy = 1'b0;
  always @(posedge clk) seen_busy <= csr_busy_i | pmi_busy_i;
  always @(negedge clk) begin
    if (!rst && ee_req_o)
      chk({1'b0, ee_addr_o} < (11'd128 << size_sel_i), "R8 fetch in range", ee_addr_o, 128 << size_sel_i);
    if (!rst && reg_we_o) begin
      writes++;
      chk(!seen_busy, "R6 write only after idle", seen_busy, 0);
      if (exp_q.size() == 0) chk(0, "R3 unexpected write", {reg_addr_o, reg_wdata_o}, 0);
      else begin
        logic [41:0] e;
        e = exp_q.pop_front();
        chk({reg_addr_o, reg_wdata_o} == e, "R3 R4 write addr/data", {reg_addr_o, reg_wdata_o}, e);
      end
    end
  end

  task automatic clr_img();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    wp = 0;
  endtask
  task automatic put(input logic [7:0] b);
    mem[wp] = b; wp++;
  endtask
  task automatic expw(input logic [9:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask
  task automatic kick();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask
  task automatic wait_done();
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic end_checks(input string tag);
    chk(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    chk(!busy_o && done_o, {tag, " R9 finished busy/done"}, {busy_o, done_o}, 2'b01);
    exp_q.delete();
  endtask
  task automatic load_example();
    clr_img();
    put(8'hA5); put(8'h03);
    put(8'h10); put(8'h01); for (int i = 1; i <= 4; i++) put(8'h10 + 8'(i));
    put(8'h20); put(8'h02); for (int i = 1; i <= 8; i++) put(8'h20 + 8'(i));
    put(8'h30); put(8'h03); for (int i = 1; i <= 12; i++) put(8'h30 + 8'(i));
  endtask
  task automatic exp_example();
    expw(10'h040, 32'h11121314);
    expw(10'h080, 32'h21222324); expw(10'h084, 32'h25262728);
    expw(10'h0C0, 32'h31323334); expw(10'h0C4, 32'h35363738); expw(10'h0C8, 32'h393A3B3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    clr_img();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({busy_o, done_o, ovf_o, reg_we_o, ee_req_o} == 5'b0, "R11 reset outputs",
        {busy_o, done_o, ovf_o, reg_we_o, ee_req_o}, 0);

    // three-burst image, random interface busy: R2 R3 R4 R7
    rnd_busy = 1;
    load_example(); exp_example();
    kick();
    chk(busy_o && !done_o, "R9 start sets busy", {busy_o, done_o}, 2'b10);
    wait_done();
    end_checks("R2 three bursts");

    // bad marker: R1
    clr_img(); put(8'h5A); put(8'h01); put(8'h10); put(8'h01);
    w0 = writes; kick(); wait_done();
    chk(writes == w0, "R1 bad marker no writes", writes - w0, 0);
    end_checks("R1");

    // zero bursts: R2
    clr_img(); put(8'hA5); put(8'h00); put(8'h10); put(8'h01);
    w0 = writes; kick(); wait_done();
    chk(writes == w0, "R2 zero bursts no writes", writes - w0, 0);
    end_checks("R2 zero");

    // zero-length burst then one DWORD: R5
    clr_img(); put(8'hA5); put(8'h02); put(8'h05); put(8'h00);
    put(8'h06); put(8'h01); put(8'hAA); put(8'hBB); put(8'hCC); put(8'hDD);
    expw(10'h018, 32'hAABBCCDD);
    kick(); wait_done(); end_checks("R5");

    // DWORD address wrap: R3
    clr_img(); put(8'hA5); put(8'h01); put(8'hFF); put(8'h02);
    for (int i = 1; i <= 8; i++) put(8'(i));
    expw(10'h3FC, 32'h01020304); expw(10'h000, 32'h05060708);
    kick(); wait_done(); end_checks("R3 wrap");

    // held busy, restart while held, release: R6 R10
    load_example(); exp_example();
    hold_csr = 1; rnd_busy = 0;
    w0 = writes; kick();
    repeat (300) @(negedge clk);
    chk(writes == w0, "R6 no write while busy held", writes - w0, 0);
    chk(busy_o, "R6 still busy while held", busy_o, 1);
    kick();
    repeat (50) @(negedge clk);
    hold_csr = 0;
    wait_done(); end_checks("R10 restart");

    // plain rerun: R10
    load_example(); exp_example();
    kick(); wait_done(); end_checks("R10 rerun");
    chk(!ovf_o, "R8 no overflow on normal runs", ovf_o, 0);

    // overflow with 128-byte strap: R8
    size_sel_i = 2'd0;
    clr_img(); put(8'hA5); put(8'h01); put(8'h00); put(8'd40);
    for (int i = 4; i < 200; i++) put(8'(i) ^ 8'h3C);
    for (int j = 0; j < 31; j++)
      expw(10'(j * 4), {mem[4 + 4*j], mem[5 + 4*j], mem[6 + 4*j], mem[7 + 4*j]});
    kick(); wait_done(); end_checks("R8 overflow");
    chk(ovf_o, "R8 overflow flag set", ovf_o, 1);

    // sticky across a good run: R8
    size_sel_i = 2'd3;
    load_example(); exp_example();
    kick(); wait_done(); end_checks("R8 sticky run");
    chk(ovf_o, "R8 overflow sticky", ovf_o, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule